// File: doc/BRIEF.md
# Lock-Stage Loop Filter Coefficient Selector

This block chooses the bandwidth code and damping code that a digital PLL loop filter applies, according to how far the loop has come toward lock. Software programs three coefficient pairs: one for the starting stage, one for acquisition and one for the locked stage. The block follows the loop through those stages and drives the active pair into the filter.

A fixed number of 1 Hz timebase ticks (two by default) after the loop closes on a selected input, the block leaves the starting stage and enters acquisition. It moves to the locked stage when lock is detected. It goes back to acquisition if lock is lost. Opening the loop holds the block in the starting stage, and so does a change of the selected input, and either event restarts the interval. When automatic selection is turned off, the locked pair drives the filter in every stage, and the stage indication keeps tracking the loop.

Top module: `lsc_coeff_selector`

## Requirements
- R1: Stage codes are 0 = starting, 1 = acquisition, 2 = locked, and code 3 never appears. After synchronous active-low reset the stage is 0 and both coefficient outputs are 0.
- R2: With automatic selection on and the stage at starting, the outputs carry the starting bandwidth and damping pair.
- R3: The starting stage lasts until START_SECS timebase ticks have been seen since the last restart. The stage becomes acquisition on the clock edge that samples the last of those ticks.
- R4: In acquisition, the stage becomes locked on the edge that samples the lock flag high. While the stage is acquisition with automatic selection on, the outputs carry the acquisition pair.
- R5: With automatic selection on and the stage at locked, the outputs carry the locked pair.
- R6: With automatic selection off, the outputs carry the locked pair in every stage, and stage progression continues as normal.
- R7: While the loop-closed flag is low, the stage is held at starting, the tick count is cleared, and ticks do not advance the stage.
- R8: A one-cycle pulse on sel_change returns the stage to starting and restarts the tick count.
- R9: If the lock flag is low while the stage is locked, the stage returns to acquisition and does not fall back to starting.
- R10: The lock flag has no effect while the stage is starting.
- R11: The outputs are registered. They reflect the stage and the pair values sampled one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_sel_en | input | 1 | 1 = pick the pair by stage, 0 = always use the locked pair |
| loop_closed | input | 1 | High while an input is selected and the loop is closed |
| sel_change | input | 1 | One-cycle pulse when the selected input changes |
| lock_det | input | 1 | Lock-detect flag for the selected input |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| start_bw | input | BW_W | Starting-stage bandwidth code |
| start_damp | input | DAMP_W | Starting-stage damping code |
| acq_bw | input | BW_W | Acquisition-stage bandwidth code |
| acq_damp | input | DAMP_W | Acquisition-stage damping code |
| lock_bw | input | BW_W | Locked-stage bandwidth code |
| lock_damp | input | DAMP_W | Locked-stage damping code |
| bw_out | output | BW_W | Active bandwidth code |
| damp_out | output | DAMP_W | Active damping code |
| stage_out | output | 2 | Current stage |

## Verification
The bench builds the block with its defaults: 5-bit bandwidth, 3-bit damping and a START_SECS of two ticks. With only two ticks in the starting interval, random tick pulses carry the loop through all three stages many times within a few thousand cycles. Random drops of the loop-closed flag and random input-change pulses then land in every stage, including mid-count in the starting interval. The 5-bit and 3-bit widths keep random pair values distinct often enough that a wrong selection shows up as a wrong code at the outputs.

// File: rtl/lsc_pkg.sv
// Shared types for the lock-stage coefficient selector.
// Assumes stage codes are fixed and visible to software through stage_out.
package lsc_pkg;
    typedef enum logic [1:0] {
        STG_START = 2'd0,
        STG_ACQ   = 2'd1,
        STG_LOCK  = 2'd2
    } stage_e;

    localparam int NUM_STAGES = 3;
endpackage

// File: rtl/lsc_interval_timer.sv
// Counts timebase ticks while the starting stage is active and pulses
// 'expired' combinationally on the tick that completes the interval.
// Assumes tick is a single-cycle pulse and clear has priority.
module lsc_interval_timer #(
    parameter int START_SECS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CNT_W = (START_SECS < 2) ? 1 : $clog2(START_SECS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(START_SECS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Final tick of the interval while running
    always_comb begin
        expired = run && tick && (cnt_q == LAST);
    end

    // Tick counter: cleared on restart, wraps when the interval ends
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            if (expired) cnt_q <= '0;
            else         cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lsc_stage_fsm.sv
// Tracks the lock progression: starting -> acquisition -> locked, with
// loss of lock falling back to acquisition and restart to starting.
// Assumes restart (loop open or input change) outranks every other event.
module lsc_stage_fsm
    import lsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   restart,
    input  logic   interval_done,
    input  logic   lock_det,
    output stage_e stage_q
);
    stage_e stage_d;

    // Next-stage decision
    always_comb begin
        stage_d = stage_q;
        if (restart) begin
            stage_d = STG_START;
        end else begin
            unique case (stage_q)
                STG_START: if (interval_done) stage_d = STG_ACQ;
                STG_ACQ:   if (lock_det)      stage_d = STG_LOCK;
                STG_LOCK:  if (!lock_det)     stage_d = STG_ACQ;
                default:                      stage_d = STG_START;
            endcase
        end
    end

    // Stage register
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= STG_START;
        else        stage_q <= stage_d;
    end
endmodule

// File: rtl/lsc_coeff_mux.sv
// Registers the coefficient pair for the effective stage.
// The effective stage is the tracked stage under automatic selection and the
// locked stage otherwise. Assumes pair arrays are indexed by stage code.
module lsc_coeff_mux
    import lsc_pkg::*;
#(
    parameter int BW_W   = 5,
    parameter int DAMP_W = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  stage_e                           stage,
    input  logic                             auto_en,
    input  logic [NUM_STAGES-1:0][BW_W-1:0]  bw_set,
    input  logic [NUM_STAGES-1:0][DAMP_W-1:0] damp_set,
    output logic [BW_W-1:0]                  bw_q,
    output logic [DAMP_W-1:0]                damp_q
);
    stage_e                              eff_stage;
    logic [NUM_STAGES-1:0]               sel;
    logic [NUM_STAGES-1:0][BW_W-1:0]     bw_term;
    logic [NUM_STAGES-1:0][DAMP_W-1:0]   damp_term;
    logic [BW_W-1:0]                     bw_d;
    logic [DAMP_W-1:0]                   damp_d;

    // Effective stage after the override
    always_comb begin
        eff_stage = auto_en ? stage : STG_LOCK;
    end

    // One-hot gated terms, one per stage
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_term
        assign sel[i]       = (eff_stage == stage_e'(i));
        assign bw_term[i]   = sel[i] ? bw_set[i]   : '0;
        assign damp_term[i] = sel[i] ? damp_set[i] : '0;
    end

    // OR-combine the gated terms
    always_comb begin
        bw_d   = '0;
        damp_d = '0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            bw_d   = bw_d   | bw_term[i];
            damp_d = damp_d | damp_term[i];
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bw_q   <= '0;
            damp_q <= '0;
        end else begin
            bw_q   <= bw_d;
            damp_q <= damp_d;
        end
    end
endmodule

// File: rtl/lsc_coeff_selector.sv
// Top of the lock-stage coefficient selector. Restarts the progression on
// loop open or input change, times the starting interval with the 1 Hz tick,
// and drives the registered coefficient pair for the current stage.
module lsc_coeff_selector
    import lsc_pkg::*;
#(
    parameter int BW_W       = 5,
    parameter int DAMP_W     = 3,
    parameter int START_SECS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_sel_en,
    input  logic              loop_closed,
    input  logic              sel_change,
    input  logic              lock_det,
    input  logic              tick_1hz,
    input  logic [BW_W-1:0]   start_bw,
    input  logic [DAMP_W-1:0] start_damp,
    input  logic [BW_W-1:0]   acq_bw,
    input  logic [DAMP_W-1:0] acq_damp,
    input  logic [BW_W-1:0]   lock_bw,
    input  logic [DAMP_W-1:0] lock_damp,
    output logic [BW_W-1:0]   bw_out,
    output logic [DAMP_W-1:0] damp_out,
    output logic [1:0]        stage_out
);
    logic                               restart;
    logic                               interval_done;
    stage_e                             stage;
    logic [NUM_STAGES-1:0][BW_W-1:0]    bw_set;
    logic [NUM_STAGES-1:0][DAMP_W-1:0]  damp_set;

    // Restart condition and stage-indexed pair arrays
    always_comb begin
        restart            = !loop_closed || sel_change;
        bw_set[STG_START]  = start_bw;
        bw_set[STG_ACQ]    = acq_bw;
        bw_set[STG_LOCK]   = lock_bw;
        damp_set[STG_START] = start_damp;
        damp_set[STG_ACQ]   = acq_damp;
        damp_set[STG_LOCK]  = lock_damp;
    end

    lsc_interval_timer #(.START_SECS(START_SECS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart),
        .run     (stage == STG_START),
        .tick    (tick_1hz),
        .expired (interval_done)
    );

    lsc_stage_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .restart       (restart),
        .interval_done (interval_done),
        .lock_det      (lock_det),
        .stage_q       (stage)
    );

    lsc_coeff_mux #(.BW_W(BW_W), .DAMP_W(DAMP_W)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage    (stage),
        .auto_en  (auto_sel_en),
        .bw_set   (bw_set),
        .damp_set (damp_set),
        .bw_q     (bw_out),
        .damp_q   (damp_out)
    );

    assign stage_out = stage;
endmodule

// File: rtl/lsc_coeff_selector_chk.sv
// Property checker for lsc_coeff_selector, attached by bind below.
// Assumes the port names of the top module.
module lsc_coeff_selector_chk #(
    parameter int BW_W       = 5,
    parameter int DAMP_W     = 3,
    parameter int START_SECS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              auto_sel_en,
    input logic              loop_closed,
    input logic              sel_change,
    input logic              lock_det,
    input logic              tick_1hz,
    input logic [BW_W-1:0]   start_bw,
    input logic [DAMP_W-1:0] start_damp,
    input logic [BW_W-1:0]   acq_bw,
    input logic [DAMP_W-1:0] acq_damp,
    input logic [BW_W-1:0]   lock_bw,
    input logic [DAMP_W-1:0] lock_damp,
    input logic [BW_W-1:0]   bw_out,
    input logic [DAMP_W-1:0] damp_out,
    input logic [1:0]        stage_out
);
    p_legal_stage_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stage_out != 2'd3);

    p_start_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_sel_en && stage_out == 2'd0) |=>
            (bw_out == $past(start_bw) && damp_out == $past(start_damp)));

    p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_out == 2'd0 && !tick_1hz) |=> stage_out == 2'd0);

    p_acq_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_sel_en && stage_out == 2'd1) |=>
            (bw_out == $past(acq_bw) && damp_out == $past(acq_damp)));

    p_locked_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_sel_en |=>
            (bw_out == $past(lock_bw) && damp_out == $past(lock_damp)));

    p_open_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_closed |=> stage_out == 2'd0);

    p_change_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_change |=> stage_out == 2'd0);

    p_loss_to_acq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_out == 2'd2 && !lock_det && loop_closed && !sel_change) |=>
            stage_out == 2'd1);

    p_no_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_out == 2'd0) |=> stage_out != 2'd2);
endmodule

bind lsc_coeff_selector lsc_coeff_selector_chk #(
    .BW_W(BW_W), .DAMP_W(DAMP_W), .START_SECS(START_SECS)
) u_chk (.*);

// File: tb/sim_lsc_coeff_selector.sv
module sim_lsc_coeff_selector;
    localparam int BW_W = 5;
    localparam int DAMP_W = 3;
    localparam int START_SECS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_sel_en = 1'b1, loop_closed = 1'b0, sel_change = 1'b0;
    logic lock_det = 1'b0, tick_1hz = 1'b0;
    logic [BW_W-1:0] start_bw = 5'd3, acq_bw = 5'd12, lock_bw = 5'd25;
    logic [DAMP_W-1:0] start_damp = 3'd1, acq_damp = 3'd4, lock_damp = 3'd6;
    logic [BW_W-1:0] bw_out;
    logic [DAMP_W-1:0] damp_out;
    logic [1:0] stage_out;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    lsc_coeff_selector #(.BW_W(BW_W), .DAMP_W(DAMP_W), .START_SECS(START_SECS)) u0 (.*);

    // Reference model built from the requirements
    logic [1:0] m_stage = 2'd0;
    int m_cnt = 0;
    logic [BW_W-1:0] m_bw = '0;
    logic [DAMP_W-1:0] m_dp = '0;
    logic [1:0] m_eff = 2'd0;

    function automatic logic [1:0] next_stage(logic [1:0] s, int c);
        if (!loop_closed || sel_change) return 2'd0;
        case (s)
            2'd0: return (tick_1hz && c == START_SECS - 1) ? 2'd1 : 2'd0;
            2'd1: return lock_det ? 2'd2 : 2'd1;
            default: return lock_det ? 2'd2 : 2'd1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stage <= 2'd0; m_cnt <= 0; m_bw <= '0; m_dp <= '0; m_eff <= 2'd0;
        end else begin
            logic [1:0] eff;
            eff = auto_sel_en ? m_stage : 2'd2;
            m_eff <= eff;
            m_bw <= (eff == 2'd0) ? start_bw : (eff == 2'd1) ? acq_bw : lock_bw;
            m_dp <= (eff == 2'd0) ? start_damp : (eff == 2'd1) ? acq_damp : lock_damp;
            m_stage <= next_stage(m_stage, m_cnt);
            if (!loop_closed || sel_change) m_cnt <= 0;
            else if (m_stage == 2'd0 && tick_1hz)
                m_cnt <= (m_cnt == START_SECS - 1) ? 0 : m_cnt + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Continuous comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            string t;
            t = (m_eff == 2'd2 && !auto_sel_en) ? "R6" :
                (m_eff == 2'd0) ? "R2" : (m_eff == 2'd1) ? "R4" : "R5";
            chk({t, " bw"}, bw_out, m_bw);
            chk({t, " damp"}, damp_out, m_dp);
            chk("R1 stage track", stage_out, m_stage);
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cyc(3);
        chk("R1 reset stage", stage_out, 0);
        chk("R1 reset bw", bw_out, 0);
        chk("R1 reset damp", damp_out, 0);
        rst_n = 1'b1; loop_closed = 1'b1;
        lock_det = 1'b1;                      // R10: lock ignored in starting
        cyc(3);
        chk("R10 lock ignored", stage_out, 0);
        chk("R2 start bw", bw_out, 3);
        tick_1hz = 1'b1; cyc(1); tick_1hz = 1'b0;
        chk("R3 after one tick", stage_out, 0);
        lock_det = 1'b0;
        tick_1hz = 1'b1; cyc(1); tick_1hz = 1'b0;
        chk("R3 after two ticks", stage_out, 1);
        chk("R11 output lags stage", bw_out, 3);
        cyc(1);
        chk("R4 acq bw", bw_out, 12);
        lock_det = 1'b1; cyc(1);
        chk("R4 to locked", stage_out, 2);
        cyc(1);
        chk("R5 locked bw", bw_out, 25);
        lock_det = 1'b0; cyc(1);
        chk("R9 loss to acq", stage_out, 1);
        lock_det = 1'b1; cyc(2);
        sel_change = 1'b1; cyc(1); sel_change = 1'b0;
        chk("R8 change restarts", stage_out, 0);
        tick_1hz = 1'b1; cyc(1); tick_1hz = 1'b0;
        loop_closed = 1'b0; cyc(1);
        tick_1hz = 1'b1; cyc(3); tick_1hz = 1'b0;
        chk("R7 open holds", stage_out, 0);
        loop_closed = 1'b1;
        tick_1hz = 1'b1; cyc(1); tick_1hz = 1'b0;
        chk("R7 count cleared", stage_out, 0);
        auto_sel_en = 1'b0; cyc(2);
        chk("R6 override bw", bw_out, 25);
        chk("R6 override damp", damp_out, 6);
        tick_1hz = 1'b1; cyc(1); tick_1hz = 1'b0;
        chk("R6 stage still runs", stage_out, 1);
        auto_sel_en = 1'b1;

        // Random phase with a fixed seed
        void'($urandom(32'd7741));
        for (int i = 0; i < 6000; i++) begin
            tick_1hz    = ($urandom % 4) == 0;
            sel_change  = ($urandom % 80) == 0;
            if (($urandom % 60) == 0) loop_closed = ~loop_closed;
            if (!loop_closed && ($urandom % 4) == 0) loop_closed = 1'b1;
            if (($urandom % 12) == 0) lock_det = ~lock_det;
            if (($urandom % 200) == 0) auto_sel_en = ~auto_sel_en;
            if (($urandom % 50) == 0) begin
                start_bw = BW_W'($urandom); acq_bw = BW_W'($urandom); lock_bw = BW_W'($urandom);
                start_damp = DAMP_W'($urandom); acq_damp = DAMP_W'($urandom);
                lock_damp = DAMP_W'($urandom);
            end
            cyc(1);
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule